// File: doc/BRIEF.md
# PHY Status Polling Monitor

This block keeps a live picture of the PHYs on a management bus without software help. Whenever the shared frame engine is not serving a user transaction, it asks the engine for a read of the basic status register of the next PHY in its rotation. It records whether the PHY answered and whether it reports a link, and then waits a programmable number of management-clock periods before the next poll. The frame engine does the serialising. This block only issues requests and takes in responses through a request/accept and response-valid handshake.

Interrupts come in two flavours, picked by a mode input. In per-PHY mode, two address selectors each name one PHY, and a change in that PHY's link state raises its own raw interrupt bit. In global-change mode, a single raw bit rises when any polled PHY's answer or link state changes. Raw bits are sticky until software clears them with a write-one pulse. Each raw bit passes to the interrupt outputs only when its enable bit is set.

Top module: `phy_poll_monitor`

## Requirements
- R1: Polls visit the enabled addresses in ascending order. After the highest enabled address, the rotation wraps to the lowest enabled one. After reset, the first poll goes to the lowest enabled address.
- R2: Address 31 is always part of the rotation, whatever the value of `pollMask[31]`. With an all-zero mask, only address 31 is polled.
- R3: After a response is taken in, the next request is not raised until exactly `pollGap` rising `mdcTick` pulses have been seen. A gap of 0 moves straight on.
- R4: Bit n of `aliveMap` equals the acknowledge flag of the most recent poll response for address n.
- R5: Every poll reads register address 1 (`pollRegAddr` = 1). Bit n of `linkMap` is set only when that poll was acknowledged and bit 2 of the returned data is 1. An unacknowledged response clears the link bit even if data bit 2 is high.
- R6: While `userBusy` is high, `pollReq` stays low. The poll is issued once `userBusy` falls.
- R7: With `stateChangeMode` = 0, a change of the link bit of the PHY named by `selPhy0` sets `intRaw[0]`, and one of `selPhy1` sets `intRaw[1]`. Link changes on other PHYs, and changes of the alive bit alone, set nothing.
- R8: With `stateChangeMode` = 1, any change of the alive or link bit of any polled PHY sets `intRaw[0]`. `intRaw[1]` is never set in this mode.
- R9: Raw bits stay set until a one is pulsed on the matching `intClear` bit. `intOut` bit i is `intRaw[i]` AND `intEnable[i]`.
- R10: When a change event and a clear of the same raw bit fall in the same cycle, the event wins and the bit stays set.
- R11: During reset, `aliveMap`, `linkMap`, `intRaw`, `intOut` and `pollReq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollMask | input | 32 | Per-address poll enable (bit 31 forced on) |
| pollGap | input | 8 | MDC periods between a response and the next poll |
| stateChangeMode | input | 1 | 0 per-PHY interrupt mode, 1 global-change mode |
| selPhy0 | input | 5 | PHY watched by raw bit 0 in per-PHY mode |
| selPhy1 | input | 5 | PHY watched by raw bit 1 in per-PHY mode |
| intEnable | input | 2 | Enables raw bits onto `intOut` |
| intClear | input | 2 | Write-one-to-clear pulse for raw bits |
| mdcTick | input | 1 | One-cycle pulse per management clock period |
| userBusy | input | 1 | Frame engine has a user transaction pending or running |
| reqAccept | input | 1 | Frame engine takes the poll request this cycle |
| rspValid | input | 1 | Poll read response valid |
| rspAck | input | 1 | PHY acknowledged the read |
| rspData | input | 16 | Data returned by the read |
| pollReq | output | 1 | Poll read request to the frame engine |
| pollPhyAddr | output | 5 | PHY address of the requested read |
| pollRegAddr | output | 5 | Register address of the requested read |
| aliveMap | output | 32 | Per-address acknowledge bitmap |
| linkMap | output | 32 | Per-address link bitmap |
| intRaw | output | 2 | Sticky raw interrupt bits |
| intOut | output | 2 | Enabled interrupt outputs |

## Verification
A set of PHYs is modelled with some absent and some linked. One absent PHY returns data with bit 2 set, so the bench can tell acknowledge gating apart from plain data capture. The mask is swept between a sparse pattern and all-zero, which separates ascending wraparound from the forced top address. Gaps of 0, 3 and 7 show whether the ticks are counted exactly or off by one. Link-only, alive-only, selected and unselected changes are applied in both modes to see which of them raise which raw bit. A clear that coincides with an event shows which of the two has priority.

// File: rtl/phy_poll_pkg.sv
package phy_poll_pkg;
  localparam int NUM_PHY = 32;
  localparam int ADDR_W  = $clog2(NUM_PHY);

  // strobes from sequencer to status datapath
  typedef struct packed {
    logic              capture;
    logic [ADDR_W-1:0] addr;
  } pollStrobe_t;

  typedef enum logic [1:0] {ST_GAP, ST_REQ, ST_WAIT} pollState_e;
endpackage

// File: rtl/phy_poll_ctrl.sv
module phy_poll_ctrl
  import phy_poll_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PHY-1:0] pollMask,
  input  logic [GAP_W-1:0]   pollGap,
  input  logic               mdcTick,
  input  logic               userBusy,
  input  logic               reqAccept,
  input  logic               rspValid,
  output logic               pollReq,
  output logic [ADDR_W-1:0]  pollPhyAddr,
  output pollStrobe_t        strobe
);
  pollState_e        state;
  logic [GAP_W-1:0]  gapCnt;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [NUM_PHY-1:0] effMask;

  // top address can never be removed from the rotation
  assign effMask = pollMask | {1'b1, {(NUM_PHY-1){1'b0}}};

  // first enabled address strictly above the current one, wrapping
  always_comb begin
    logic found;
    found    = 1'b0;
    nextAddr = curAddr;
    for (int k = 1; k <= NUM_PHY; k++) begin
      int j;
      j = (int'(curAddr) + k) % NUM_PHY;
      if (!found && effMask[j]) begin
        nextAddr = ADDR_W'(j);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_GAP;
      gapCnt  <= '0;
      curAddr <= ADDR_W'(NUM_PHY - 1);
    end else begin
      unique case (state)
        ST_GAP: begin
          if (gapCnt == '0) begin
            curAddr <= nextAddr;
            state   <= ST_REQ;
          end else if (mdcTick) begin
            gapCnt <= gapCnt - GAP_W'(1);
          end
        end
        ST_REQ: if (pollReq && reqAccept) state <= ST_WAIT;
        ST_WAIT: begin
          if (rspValid) begin
            state  <= ST_GAP;
            gapCnt <= pollGap;
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end

  assign pollReq        = (state == ST_REQ) && !userBusy;
  assign pollPhyAddr    = curAddr;
  assign strobe.capture = (state == ST_WAIT) && rspValid;
  assign strobe.addr    = curAddr;
endmodule

// File: rtl/phy_poll_datapath.sv
module phy_poll_datapath
  import phy_poll_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LINK_BIT = 2,
  parameter int NUM_INT  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  pollStrobe_t        strobe,
  input  logic               rspAck,
  input  logic [DATA_W-1:0]  rspData,
  input  logic               stateChangeMode,
  input  logic [ADDR_W-1:0]  selPhy0,
  input  logic [ADDR_W-1:0]  selPhy1,
  input  logic [NUM_INT-1:0] intEnable,
  input  logic [NUM_INT-1:0] intClear,
  output logic [NUM_PHY-1:0] aliveMap,
  output logic [NUM_PHY-1:0] linkMap,
  output logic [NUM_INT-1:0] intRaw,
  output logic [NUM_INT-1:0] intOut
);
  logic newAlive, newLink, linkDiff, anyDiff;
  logic [NUM_INT-1:0] event_;

  assign newAlive = rspAck;
  assign newLink  = rspAck & rspData[LINK_BIT];
  assign linkDiff = strobe.capture && (newLink != linkMap[strobe.addr]);
  assign anyDiff  = linkDiff ||
                    (strobe.capture && (newAlive != aliveMap[strobe.addr]));

  always_comb begin
    event_ = '0;
    if (stateChangeMode) begin
      event_[0] = anyDiff;
    end else begin
      event_[0] = linkDiff && (strobe.addr == selPhy0);
      event_[1] = linkDiff && (strobe.addr == selPhy1);
    end
  end

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_phy
    always_ff @(posedge clk) begin
      if (!rstN) begin
        aliveMap[g] <= 1'b0;
        linkMap[g]  <= 1'b0;
      end else if (strobe.capture && strobe.addr == ADDR_W'(g)) begin
        aliveMap[g] <= newAlive;
        linkMap[g]  <= newLink;
      end
    end
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) intRaw <= '0;
    else       intRaw <= (intRaw & ~intClear) | event_;
  end

  assign intOut = intRaw & intEnable;
endmodule

// File: rtl/phy_poll_monitor.sv
module phy_poll_monitor
  import phy_poll_pkg::*;
#(
  parameter int GAP_W    = 8,
  parameter int DATA_W   = 16,
  parameter int LINK_BIT = 2,
  parameter int STAT_REG = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       pollMask,
  input  logic [GAP_W-1:0]  pollGap,
  input  logic              stateChangeMode,
  input  logic [4:0]        selPhy0,
  input  logic [4:0]        selPhy1,
  input  logic [1:0]        intEnable,
  input  logic [1:0]        intClear,
  input  logic              mdcTick,
  input  logic              userBusy,
  input  logic              reqAccept,
  input  logic              rspValid,
  input  logic              rspAck,
  input  logic [DATA_W-1:0] rspData,
  output logic              pollReq,
  output logic [4:0]        pollPhyAddr,
  output logic [4:0]        pollRegAddr,
  output logic [31:0]       aliveMap,
  output logic [31:0]       linkMap,
  output logic [1:0]        intRaw,
  output logic [1:0]        intOut
);
  pollStrobe_t strobe;

  assign pollRegAddr = 5'(STAT_REG);

  phy_poll_ctrl #(.GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pollMask(pollMask), .pollGap(pollGap),
    .mdcTick(mdcTick), .userBusy(userBusy), .reqAccept(reqAccept),
    .rspValid(rspValid), .pollReq(pollReq), .pollPhyAddr(pollPhyAddr),
    .strobe(strobe)
  );

  phy_poll_datapath #(.DATA_W(DATA_W), .LINK_BIT(LINK_BIT), .NUM_INT(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rspAck(rspAck),
    .rspData(rspData), .stateChangeMode(stateChangeMode),
    .selPhy0(selPhy0), .selPhy1(selPhy1), .intEnable(intEnable),
    .intClear(intClear), .aliveMap(aliveMap), .linkMap(linkMap),
    .intRaw(intRaw), .intOut(intOut)
  );
endmodule

// File: rtl/phy_poll_monitor_checker.sv
module phy_poll_monitor_checker (
  input logic        clk,
  input logic        rstN,
  input logic        userBusy,
  input logic        pollReq,
  input logic        rspValid,
  input logic        stateChangeMode,
  input logic [1:0]  intClear,
  input logic [1:0]  intRaw,
  input logic [31:0] aliveMap,
  input logic [31:0] linkMap
);
  // R6: user traffic blocks polling
  a_r6_user_priority: assert property (@(posedge clk) disable iff (!rstN)
    userBusy |-> !pollReq);

  // R5: a link bit needs an acknowledged poll
  a_r5_link_needs_alive: assert property (@(posedge clk) disable iff (!rstN)
    (linkMap & ~aliveMap) == 32'h0);

  // R4: bitmaps only move on a response
  a_r4_maps_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |=> ($stable(aliveMap) && $stable(linkMap)));

  // R9: raw bits are sticky without a clear
  a_r9_raw0_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (intRaw[0] && !intClear[0]) |=> intRaw[0]);
  a_r9_raw1_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (intRaw[1] && !intClear[1]) |=> intRaw[1]);

  // R8: second line stays quiet in global-change mode
  a_r8_bit1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stateChangeMode && !intRaw[1]) |=> !intRaw[1]);
endmodule

bind phy_poll_monitor phy_poll_monitor_checker u_checker (
  .clk(clk), .rstN(rstN), .userBusy(userBusy), .pollReq(pollReq),
  .rspValid(rspValid), .stateChangeMode(stateChangeMode),
  .intClear(intClear), .intRaw(intRaw), .aliveMap(aliveMap),
  .linkMap(linkMap)
);

// File: tb/phy_poll_monitor_bench.sv
module phy_poll_monitor_bench;
  logic        clk = 0;
  logic        rstN;
  logic [31:0] pollMask;
  logic [7:0]  pollGap;
  logic        stateChangeMode;
  logic [4:0]  selPhy0, selPhy1;
  logic [1:0]  intEnable, intClear;
  logic        mdcTick, userBusy, reqAccept, rspValid, rspAck;
  logic [15:0] rspData;
  logic        pollReq;
  logic [4:0]  pollPhyAddr, pollRegAddr;
  logic [31:0] aliveMap, linkMap;
  logic [1:0]  intRaw, intOut;

  always #10 clk = ~clk;

  phy_poll_monitor u_phy_poll_monitor (
    .clk(clk), .rstN(rstN), .pollMask(pollMask), .pollGap(pollGap),
    .stateChangeMode(stateChangeMode), .selPhy0(selPhy0), .selPhy1(selPhy1),
    .intEnable(intEnable), .intClear(intClear), .mdcTick(mdcTick),
    .userBusy(userBusy), .reqAccept(reqAccept), .rspValid(rspValid),
    .rspAck(rspAck), .rspData(rspData), .pollReq(pollReq),
    .pollPhyAddr(pollPhyAddr), .pollRegAddr(pollRegAddr),
    .aliveMap(aliveMap), .linkMap(linkMap), .intRaw(intRaw), .intOut(intOut)
  );

  assign reqAccept = pollReq;

  int nChecks = 0, nFails = 0;
  bit present [32];
  bit linkUp  [32];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nextExp(int last, logic [31:0] m);
    logic [31:0] e;
    e = m | 32'h8000_0000;
    for (int k = 1; k <= 32; k++) begin
      if (e[(last + k) % 32]) return (last + k) % 32;
    end
    return last;
  endfunction

  // frame engine, PHY and MDC tick model, all driven on the falling edge
  int respCount = 0, reqCount = 0, lastReq = 31, lastRegAddr = 0;
  int pa = 0, dly = 0, gapTicks = 0, tickDiv = 0, clrAddr = 0;
  bit pending = 0, counting = 0, busySeen = 0, lastTick = 0, justReq = 0;
  bit skipSeq = 0, skipGap = 0, clrArm = 0, clrOn = 0, busyReqSeen = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      pending = 0; counting = 0; rspValid = 0; mdcTick = 0; lastReq = 31;
    end else begin
      rspValid = 0;
      justReq  = 0;
      if (clrOn) begin intClear = 2'b00; clrOn = 0; end
      if (userBusy && pollReq) busyReqSeen = 1;
      if (pollReq && !pending) begin
        reqCount++;
        lastRegAddr = int'(pollRegAddr);
        if (!skipSeq)
          chk(int'(pollPhyAddr) == nextExp(lastReq, pollMask), "R1 order",
              32'(pollPhyAddr), 32'(nextExp(lastReq, pollMask)));
        if (counting && !busySeen && !skipGap)
          chk((gapTicks - int'(lastTick)) == int'(pollGap), "R3 gap",
              32'(gapTicks - int'(lastTick)), 32'(pollGap));
        skipSeq = 0; skipGap = 0; counting = 0; busySeen = 0;
        lastReq = int'(pollPhyAddr);
        pa = lastReq; dly = 2; pending = 1; justReq = 1;
      end
      tickDiv = (tickDiv + 1) % 4;
      mdcTick = (tickDiv == 0);
      if (counting) gapTicks += int'(mdcTick);
      if (userBusy) busySeen = 1;
      lastTick = mdcTick;
      if (pending && !justReq) begin
        if (dly == 0) begin
          rspValid = 1;
          rspAck   = present[pa];
          rspData  = present[pa] ? (16'h7869 | (linkUp[pa] ? 16'h0004 : 16'h0000))
                                 : 16'hFFFF;
          pending = 0; respCount++; counting = 1; gapTicks = 0;
          if (clrArm && pa == clrAddr) begin
            intClear = 2'b01; clrOn = 1; clrArm = 0;
          end
        end else dly--;
      end
    end
  end

  task automatic waitPolls(input int n);
    int target;
    target = respCount + n;
    while (respCount < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseClear(input logic [1:0] v);
    @(negedge clk) intClear = v;
    @(negedge clk) intClear = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    int startReq;
    rstN = 0; pollMask = 32'h0000_0125; pollGap = 8'd3; stateChangeMode = 0;
    selPhy0 = 5'd2; selPhy1 = 5'd5; intEnable = 2'b11; intClear = 2'b00;
    userBusy = 0; rspAck = 0; rspData = '0; mdcTick = 0; rspValid = 0;
    for (int i = 0; i < 32; i++) begin present[i] = 0; linkUp[i] = 0; end
    present[0] = 1; present[2] = 1; present[5] = 1; present[31] = 1;
    linkUp[0] = 1; linkUp[5] = 1; linkUp[8] = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(aliveMap == 0 && linkMap == 0, "R11 maps", aliveMap | linkMap, 0);
    chk(intRaw == 0 && intOut == 0 && !pollReq, "R11 int/req",
        {intRaw, intOut, 27'(pollReq)}, 0);
    rstN = 1;

    // first rotations: bitmaps and per-PHY interrupts
    waitPolls(7);
    chk(aliveMap == 32'h8000_0025, "R4 alive", aliveMap, 32'h8000_0025);
    chk(linkMap == 32'h0000_0021, "R5 link gated by ack", linkMap, 32'h21);
    chk(intRaw == 2'b10, "R7 sel1 link change, sel0 alive-only ignored",
        32'(intRaw), 32'h2);
    chk(lastRegAddr == 1, "R5 reg addr", 32'(lastRegAddr), 1);
    pulseClear(2'b11);
    chk(intRaw == 0 && intOut == 0, "R9 clear", 32'(intRaw), 0);

    // enable masking and per-bit clear
    intEnable = 2'b01; linkUp[2] = 1;
    waitPolls(6);
    chk(intRaw == 2'b01 && intOut == 2'b01, "R7 sel0 link change",
        {intRaw, intOut}, 32'h5);
    linkUp[5] = 0;
    waitPolls(6);
    chk(intRaw == 2'b11, "R7 sel1 link drop", 32'(intRaw), 32'h3);
    chk(intOut == 2'b01, "R9 enable mask", 32'(intOut), 32'h1);
    pulseClear(2'b10);
    chk(intRaw == 2'b01, "R9 single-bit clear", 32'(intRaw), 32'h1);
    pulseClear(2'b11);

    // unselected PHY change in per-PHY mode
    present[8] = 1;
    waitPolls(6);
    chk(intRaw == 2'b00, "R7 unselected ignored", 32'(intRaw), 0);
    chk(aliveMap == 32'h8000_0125 && linkMap == 32'h0000_0105, "R4 new PHY",
        aliveMap ^ linkMap, 32'h8000_0020);

    // global-change mode
    stateChangeMode = 1; intEnable = 2'b11; linkUp[8] = 0;
    waitPolls(6);
    chk(intRaw == 2'b01, "R8 any link change", 32'(intRaw), 32'h1);
    pulseClear(2'b11);
    present[31] = 0;
    waitPolls(6);
    chk(intRaw == 2'b01, "R8 alive-only change", 32'(intRaw), 32'h1);
    chk(aliveMap == 32'h0000_0125, "R4 alive drop", aliveMap, 32'h125);
    pulseClear(2'b11);
    waitPolls(6);
    chk(intRaw == 2'b00, "R8 steady no event", 32'(intRaw), 0);

    // R10 clear coinciding with an event
    clrAddr = 5; clrArm = 1; linkUp[5] = 1;
    waitPolls(6);
    chk(intRaw == 2'b01, "R10 event beats clear", 32'(intRaw), 32'h1);
    chk(!clrArm, "R10 collision exercised", 32'(clrArm), 0);
    pulseClear(2'b01);

    // gap variants
    pollGap = 8'd0; skipGap = 1;
    waitPolls(6);
    pollGap = 8'd7; skipGap = 1;
    waitPolls(6);

    // R6 user priority
    busyReqSeen = 0; startReq = reqCount;
    @(negedge clk) userBusy = 1;
    repeat (60) @(negedge clk);
    chk(!busyReqSeen, "R6 no poll while busy", 32'(busyReqSeen), 0);
    userBusy = 0;
    waitPolls(2);
    chk(reqCount > startReq, "R6 resumes", 32'(reqCount), 32'(startReq + 1));

    // R2 forced top address
    pollMask = 32'h0; skipSeq = 1;
    waitPolls(4);
    chk(lastReq == 31, "R2 only top address", 32'(lastReq), 31);
    pollMask = 32'h7FFF_FFFF; skipSeq = 1;
    waitPolls(3);
    chk(lastReq != 31 || aliveMap[31] == 1'b0, "R2 top with mask bit clear",
        32'(lastReq), 32'(lastReq));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule